// File: doc/BRIEF.md
# Cartridge Bank Address Translator

This block turns a CPU address and a PPU address into physical offsets for a cartridge's program ROM, work RAM and pattern memory. It reads four 5-bit configuration words: a control word, two pattern-bank words and a program-bank word. It also reads a flag that records whether the most recent register commit landed in the 0xC000-0xDFFF range, and a handful of board options. The options are an early-revision flag, a large-ROM flag, a fixed-32K flag and the number of 16K program banks fitted.

The control word picks the nametable mirroring code. It also picks one of four program window schemes and either 8K or split 4K pattern banking. On large boards, bit 4 of a pattern-bank word becomes an outer 256K select for the program ROM. Which pattern word supplies that bit depends on the pattern mode and on where the last commit landed. Every output is registered and appears one clock after the inputs it depends on. Register loading and the memory arrays belong to neighbouring blocks.

Top module: `cart_bank_xlate`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs clear to zero on that edge. Otherwise every output reflects the inputs sampled at the previous rising edge.
- R2: `mirror` equals control bits 1:0. The codes are 0 for single-screen lower, 1 for single-screen upper, 2 for vertical and 3 for horizontal.
- R3: With control bits 3:2 equal to 0 or 1, the CPU range 0x8000-0xFFFF maps to one 32K window. The 16K bank index is program bits 3:1 (bits 3:1 of the index), followed by CPU address bit 14 as index bit 0.
- R4: With program mode 2, 0x8000-0xBFFF maps to 16K bank 0. 0xC000-0xFFFF maps to the bank given by program bits 3:0.
- R5: With program mode 3, 0x8000-0xBFFF maps to the bank given by program bits 3:0. 0xC000-0xFFFF maps to the last bank, which is the bank count minus one.
- R6: With `fixed32` set, the 16K bank index is CPU address bit 14, whatever the mode, the program word and the outer select.
- R7: With `big_prg` set, bit 4 of a pattern word is ORed into bit 4 of every program bank index. The high pattern word supplies it when control bit 4 is 1 and `last_hi` is 1; otherwise the low pattern word supplies it. With `big_prg` clear, no bit is ORed in.
- R8: Every program bank index is reduced modulo `prg_banks`, which is a power of two from 2 to 32. `rom_off` is the reduced index times 16384 plus CPU address bits 13:0.
- R9: With control bit 4 at 0, `chr_off` is the low pattern word with bit 0 cleared, times 4096, plus PPU address bits 12:0.
- R10: With control bit 4 at 1, PPU addresses below 0x1000 use the low pattern word as a 4K bank. Addresses at 0x1000 and above use the high pattern word. The offset is the bank times 4096 plus PPU address bits 11:0.
- R11: `ram_sel` is high only for CPU addresses 0x6000-0x7FFF, and only while program word bit 4 is 0 or `rev_a` is 1. `ram_off` is CPU address bits 12:0.
- R12: `rom_sel` is high exactly when CPU address bit 15 is 1, and it is never high together with `ram_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_reg | input | 5 | Control word: mirroring, program mode, pattern mode |
| chr_lo_reg | input | 5 | Low pattern-bank word |
| chr_hi_reg | input | 5 | High pattern-bank word |
| prg_reg | input | 5 | Program bank (bits 3:0) and work-RAM disable (bit 4) |
| last_hi | input | 1 | Last commit targeted 0xC000-0xDFFF |
| rev_a | input | 1 | Early-revision board: work RAM always enabled |
| big_prg | input | 1 | 512K program ROM: outer select active |
| fixed32 | input | 1 | Program ROM fixed as one 32K bank |
| prg_banks | input | 6 | Number of 16K program banks fitted |
| cpu_addr | input | 16 | CPU address |
| ppu_addr | input | 13 | PPU pattern address |
| rom_sel | output | 1 | Program ROM access |
| rom_off | output | 19 | Program ROM byte offset |
| ram_sel | output | 1 | Work RAM access |
| ram_off | output | 13 | Work RAM byte offset |
| chr_off | output | 17 | Pattern memory byte offset |
| mirror | output | 2 | Nametable mirroring code |

## Verification
The assertions assume that `prg_banks` is a power of two between 2 and 32. The R8 bound on `rom_off` does not hold for other values, so the stimulus only ever draws the count from that set. They also assume that all inputs stay settled across each rising edge. The bench meets this by changing inputs only on falling edges. Outputs are compared one full cycle after the inputs that produced them.

// File: rtl/cart_xlate_pkg.sv
package cart_xlate_pkg;
  localparam int CPU_AW  = 16;
  localparam int PPU_AW  = 13;
  localparam int REG_W   = 5;
  localparam int WIN16_W = 14;
  localparam int WIN4_W  = 12;
  localparam int RAM_AW  = 13;

  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORZ   = 2'd3
  } mirror_e;

  typedef enum logic [1:0] {
    PM_WIDE_A  = 2'd0,
    PM_WIDE_B  = 2'd1,
    PM_FIRST_FIX = 2'd2,
    PM_LAST_FIX  = 2'd3
  } prg_mode_e;
endpackage

// File: rtl/cart_prg_map.sv
module cart_prg_map
  import cart_xlate_pkg::*;
#(
  parameter int BANK_W = 5
) (
  input  logic [REG_W-1:0] ctrl_reg,
  input  logic [REG_W-1:0] chr_lo_reg,
  input  logic [REG_W-1:0] chr_hi_reg,
  input  logic [REG_W-1:0] prg_reg,
  input  logic             last_hi,
  input  logic             big_prg,
  input  logic             fixed32,
  input  logic [BANK_W:0]  bank_cnt,
  input  logic             a14,
  output logic [BANK_W-1:0] bank16
);
  localparam int SEL_W = BANK_W - 1;

  prg_mode_e          mode;
  logic               outer_bit;
  logic [BANK_W-1:0]  outer_v;
  logic [BANK_W:0]    last_full;
  logic [BANK_W-1:0]  last_bank;
  logic [BANK_W-1:0]  sel_bank;
  logic [BANK_W-1:0]  raw;

  always_comb begin
    mode      = prg_mode_e'(ctrl_reg[3:2]);
    outer_bit = big_prg & ((ctrl_reg[4] & last_hi) ? chr_hi_reg[4] : chr_lo_reg[4]);
    outer_v   = {outer_bit, {SEL_W{1'b0}}};
    last_full = bank_cnt - 1'b1;
    last_bank = last_full[BANK_W-1:0];
    sel_bank  = {1'b0, prg_reg[SEL_W-1:0]};
    if (fixed32) begin
      raw = {{(BANK_W-1){1'b0}}, a14};
    end else begin
      unique case (mode)
        PM_WIDE_A, PM_WIDE_B: raw = outer_v | {1'b0, prg_reg[SEL_W-1:1], a14};
        PM_FIRST_FIX:         raw = a14 ? (outer_v | sel_bank) : outer_v;
        PM_LAST_FIX:          raw = a14 ? (outer_v | last_bank) : (outer_v | sel_bank);
        default:              raw = '0;
      endcase
    end
    bank16 = raw & last_bank;
  end
endmodule

// File: rtl/cart_chr_map.sv
module cart_chr_map
  import cart_xlate_pkg::*;
#(
  parameter int CHR_BANK_W = 5
) (
  input  logic                          split4k,
  input  logic [REG_W-1:0]              chr_lo_reg,
  input  logic [REG_W-1:0]              chr_hi_reg,
  input  logic [PPU_AW-1:0]             ppu_addr,
  output logic [CHR_BANK_W+WIN4_W-1:0]  chr_off
);
  logic [CHR_BANK_W-1:0] bank4;

  always_comb begin
    if (split4k)
      bank4 = ppu_addr[WIN4_W] ? chr_hi_reg[CHR_BANK_W-1:0] : chr_lo_reg[CHR_BANK_W-1:0];
    else
      bank4 = {chr_lo_reg[CHR_BANK_W-1:1], ppu_addr[WIN4_W]};
    chr_off = {bank4, ppu_addr[WIN4_W-1:0]};
  end
endmodule

// File: rtl/cart_ram_map.sv
module cart_ram_map
  import cart_xlate_pkg::*;
(
  input  logic              rev_a,
  input  logic              ram_off_bit,
  input  logic [CPU_AW-1:0] cpu_addr,
  output logic              ram_sel,
  output logic [RAM_AW-1:0] ram_off
);
  logic in_window;

  always_comb begin
    in_window = (cpu_addr[CPU_AW-1:RAM_AW] == 3'b011);
    ram_sel   = in_window & (rev_a | ~ram_off_bit);
    ram_off   = cpu_addr[RAM_AW-1:0];
  end
endmodule

// File: rtl/cart_bank_xlate.sv
module cart_bank_xlate
  import cart_xlate_pkg::*;
#(
  parameter int PRG_BANK_W = 5,
  parameter int CHR_BANK_W = 5,
  localparam int ROM_OFF_W = PRG_BANK_W + WIN16_W,
  localparam int CHR_OFF_W = CHR_BANK_W + WIN4_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [REG_W-1:0]       ctrl_reg,
  input  logic [REG_W-1:0]       chr_lo_reg,
  input  logic [REG_W-1:0]       chr_hi_reg,
  input  logic [REG_W-1:0]       prg_reg,
  input  logic                   last_hi,
  input  logic                   rev_a,
  input  logic                   big_prg,
  input  logic                   fixed32,
  input  logic [PRG_BANK_W:0]    prg_banks,
  input  logic [CPU_AW-1:0]      cpu_addr,
  input  logic [PPU_AW-1:0]      ppu_addr,
  output logic                   rom_sel,
  output logic [ROM_OFF_W-1:0]   rom_off,
  output logic                   ram_sel,
  output logic [RAM_AW-1:0]      ram_off,
  output logic [CHR_OFF_W-1:0]   chr_off,
  output logic [1:0]             mirror
);
  logic [PRG_BANK_W-1:0] bank16_c;
  logic [CHR_OFF_W-1:0]  chr_off_c;
  logic                  ram_sel_c;
  logic [RAM_AW-1:0]     ram_off_c;
  mirror_e               mirror_c;
  logic                  primed;

  cart_prg_map #(.BANK_W(PRG_BANK_W)) u_prg (
    .ctrl_reg(ctrl_reg), .chr_lo_reg(chr_lo_reg), .chr_hi_reg(chr_hi_reg),
    .prg_reg(prg_reg), .last_hi(last_hi), .big_prg(big_prg), .fixed32(fixed32),
    .bank_cnt(prg_banks), .a14(cpu_addr[WIN16_W]), .bank16(bank16_c)
  );

  cart_chr_map #(.CHR_BANK_W(CHR_BANK_W)) u_chr (
    .split4k(ctrl_reg[4]), .chr_lo_reg(chr_lo_reg), .chr_hi_reg(chr_hi_reg),
    .ppu_addr(ppu_addr), .chr_off(chr_off_c)
  );

  cart_ram_map u_ram (
    .rev_a(rev_a), .ram_off_bit(prg_reg[4]), .cpu_addr(cpu_addr),
    .ram_sel(ram_sel_c), .ram_off(ram_off_c)
  );

  assign mirror_c = mirror_e'(ctrl_reg[1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_sel <= 1'b0;
      rom_off <= '0;
      ram_sel <= 1'b0;
      ram_off <= '0;
      chr_off <= '0;
      mirror  <= MIR_ONE_LO;
      primed  <= 1'b0;
    end else begin
      rom_sel <= cpu_addr[CPU_AW-1];
      rom_off <= {bank16_c, cpu_addr[WIN16_W-1:0]};
      ram_sel <= ram_sel_c;
      ram_off <= ram_off_c;
      chr_off <= chr_off_c;
      mirror  <= mirror_c;
      primed  <= 1'b1;
    end
  end

  // R12
  sel_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rom_sel && ram_sel));

  // R12
  rom_sel_chk: assert property (@(posedge clk) disable iff (rst)
    primed |-> (rom_sel == $past(cpu_addr[CPU_AW-1])));

  // R2
  mirror_chk: assert property (@(posedge clk) disable iff (rst)
    primed |-> (mirror == $past(ctrl_reg[1:0])));

  // R11
  ram_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && ram_sel) |-> ($past(rev_a) || !$past(prg_reg[4])));

  // R8
  rom_bound_chk: assert property (@(posedge clk) disable iff (rst)
    primed |-> ({1'b0, rom_off[ROM_OFF_W-1:WIN16_W]} < $past(prg_banks)));

  // R6
  fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(fixed32)) |-> (rom_off[ROM_OFF_W-1:WIN16_W+1] == '0));

  // R10
  chr_low_chk: assert property (@(posedge clk) disable iff (rst)
    primed |-> (chr_off[WIN4_W-1:0] == $past(ppu_addr[WIN4_W-1:0])));

  // R1
  reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!rom_sel && !ram_sel && mirror == MIR_ONE_LO));
endmodule

// File: tb/tb_cart_bank_xlate.sv
module tb_cart_bank_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  ctrl_reg = '0, chr_lo_reg = '0, chr_hi_reg = '0, prg_reg = '0;
  logic        last_hi = 1'b0, rev_a = 1'b0, big_prg = 1'b0, fixed32 = 1'b0;
  logic [5:0]  prg_banks = 6'd16;
  logic [15:0] cpu_addr = '0;
  logic [12:0] ppu_addr = '0;
  logic        rom_sel, ram_sel;
  logic [18:0] rom_off;
  logic [12:0] ram_off;
  logic [16:0] chr_off;
  logic [1:0]  mirror;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cart_bank_xlate dut (
    .clk(clk), .rst(rst), .ctrl_reg(ctrl_reg), .chr_lo_reg(chr_lo_reg),
    .chr_hi_reg(chr_hi_reg), .prg_reg(prg_reg), .last_hi(last_hi), .rev_a(rev_a),
    .big_prg(big_prg), .fixed32(fixed32), .prg_banks(prg_banks),
    .cpu_addr(cpu_addr), .ppu_addr(ppu_addr), .rom_sel(rom_sel), .rom_off(rom_off),
    .ram_sel(ram_sel), .ram_off(ram_off), .chr_off(chr_off), .mirror(mirror)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model: arithmetic on integers from the requirement text.
  int e_rom_off, e_ram_off, e_chr_off, e_mirror, e_rom_sel, e_ram_sel;
  string rom_tag;
  task automatic model();
    int c = int'(ctrl_reg), lo = int'(chr_lo_reg), hi = int'(chr_hi_reg);
    int p = int'(prg_reg), cnt = int'(prg_banks), a = int'(cpu_addr), v = int'(ppu_addr);
    int mode = (c / 4) % 4, bank = p % 16, half = (a / 16384) % 2, outer = 0, b;
    if (big_prg) begin
      int src = (c >= 16 && last_hi) ? hi : lo;
      if (src >= 16) outer = 16;
    end
    if (fixed32) begin b = half; rom_tag = "R6"; end
    else if (mode < 2) begin b = outer + (bank / 2) * 2 + half; rom_tag = "R3"; end
    else if (mode == 2) begin b = half ? (outer | bank) : outer; rom_tag = "R4"; end
    else begin b = half ? (outer | (cnt - 1)) : (outer | bank); rom_tag = "R5"; end
    b = b % cnt;
    e_rom_off = b * 16384 + a % 16384;
    e_rom_sel = (a >= 32768) ? 1 : 0;
    e_ram_sel = (a >= 24576 && a < 32768 && (rev_a || p < 16)) ? 1 : 0;
    e_ram_off = a % 8192;
    if (c >= 16) e_chr_off = ((v >= 4096) ? hi : lo) * 4096 + v % 4096;
    else e_chr_off = (lo / 2) * 8192 + v;
    e_mirror = c % 4;
  endtask

  // Inputs are set just after a falling edge; results are compared at the next falling edge.
  task automatic step(string tag);
    string rt;
    model();
    @(negedge clk);
    rt = (tag != "") ? tag : rom_tag;
    chk(rt, int'(rom_off), e_rom_off);
    chk("R12", int'(rom_sel), e_rom_sel);
    chk("R11", int'(ram_sel), e_ram_sel);
    chk("R11", int'(ram_off), e_ram_off);
    chk(ctrl_reg[4] ? "R10" : "R9", int'(chr_off), e_chr_off);
    chk("R2", int'(mirror), e_mirror);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    ctrl_reg = 5'h1F; cpu_addr = 16'hFFFF; ppu_addr = 13'h1FFF; prg_reg = 5'h0F;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    chk("R1", int'(rom_sel), 0); chk("R1", int'(ram_sel), 0);
    chk("R1", int'(rom_off), 0); chk("R1", int'(chr_off), 0); chk("R1", int'(mirror), 0);
    rst = 1'b0;
    step("R1");

    // R2 each mirroring code
    for (int m = 0; m < 4; m++) begin ctrl_reg = 5'(m); step(""); end
    // R3 32K mode, odd bank number
    ctrl_reg = 5'h04; prg_reg = 5'h07; prg_banks = 6'd16;
    cpu_addr = 16'h8123; step("R3"); cpu_addr = 16'hC456; step("R3");
    // R4 first fixed
    ctrl_reg = 5'h08; prg_reg = 5'h05;
    cpu_addr = 16'h9000; step("R4"); cpu_addr = 16'hE000; step("R4");
    // R5 last fixed
    ctrl_reg = 5'h0C; prg_banks = 6'd8; prg_reg = 5'h02;
    cpu_addr = 16'hA000; step("R5"); cpu_addr = 16'hFFFF; step("R5");
    // R6 fixed 32K ignores mode and bank
    fixed32 = 1'b1; prg_reg = 5'h0B; cpu_addr = 16'hC001; step("R6"); fixed32 = 1'b0;
    // R7 outer select source
    prg_banks = 6'd32; big_prg = 1'b1; chr_lo_reg = 5'h10; chr_hi_reg = 5'h00;
    ctrl_reg = 5'h1C; last_hi = 1'b1; cpu_addr = 16'h8000; step("R7");
    last_hi = 1'b0; step("R7");
    ctrl_reg = 5'h0C; last_hi = 1'b1; step("R7");
    big_prg = 1'b0; step("R7");
    // R8 modulo
    prg_banks = 6'd2; ctrl_reg = 5'h0C; prg_reg = 5'h0F; cpu_addr = 16'h8010; step("R8");
    // R9 / R10 pattern banking
    ctrl_reg = 5'h00; chr_lo_reg = 5'h0B; ppu_addr = 13'h1234; step("");
    ctrl_reg = 5'h10; chr_hi_reg = 5'h16; step(""); ppu_addr = 13'h0ABC; step("");
    // R11 work RAM gating
    cpu_addr = 16'h6ABC; prg_reg = 5'h10; rev_a = 1'b0; step("");
    rev_a = 1'b1; step(""); rev_a = 1'b0; prg_reg = 5'h00; step("");
    cpu_addr = 16'h5FFF; step(""); cpu_addr = 16'h8000; step("");

    for (int i = 0; i < 3000; i++) begin
      ctrl_reg = 5'($urandom); chr_lo_reg = 5'($urandom); chr_hi_reg = 5'($urandom);
      prg_reg = 5'($urandom); last_hi = 1'($urandom); rev_a = 1'($urandom);
      big_prg = 1'($urandom); fixed32 = (($urandom % 8) == 0);
      prg_banks = 6'(2 << ($urandom % 5));
      cpu_addr = 16'($urandom); ppu_addr = 13'($urandom);
      step("");
    end

    // R1: reset mid-run clears outputs
    rst = 1'b1; cpu_addr = 16'h8000; ctrl_reg = 5'h03;
    @(negedge clk);
    chk("R1", int'(rom_sel), 0); chk("R1", int'(mirror), 0);
    rst = 1'b0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule